// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-controlled master for the two-wire PHY management bus. It generates the management clock (MDC), drives the bidirectional data line (MDIO) through an output, an output-enable and an input pin, and serializes one management frame for each accepted command. One register set covers both the short-address framing (Clause 22) and the extended framing (Clause 45). A mode bit in the clock register selects how the 2-bit operation field in the command register maps to the opcode sent on the wire.

The register port is a plain 64-bit write/read port. Writes take effect on the clock edge, and read data is combinational from the selected register. There are five registers, selected by `bus_word`, which is the byte offset divided by eight:

- 0 is the command register.
- 1 is the outgoing data register.
- 2 is the returned data register.
- 3 is the MDC configuration register.
- 4 is the enable register.

Software loads the outgoing data register first and then writes the command register. It then polls the pending flag of the data register that matches the frame. In extended mode, a register access takes two commands: an address frame, whose 16-bit payload comes from the outgoing data register, followed by a read or a write frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command, outgoing and returned data registers read 0, the configuration register reads 0x1205 (half period 5, sample point 2, preamble on, short framing), the enable register reads 1, MDC is low and `mdio_oe` is low.
- R2: The command register keeps the register/device address in bits 4:0, the PHY address in bits 12:8 and the operation in bits 17:16, and reads back exactly these fields of the accepted command. Both data registers carry data in bits 15:0, valid in bit 16 and pending in bit 17.
- R3: In short framing (configuration bit 24 = 0) a frame is sent MSB first as start code 01, then the wire opcode, then the 5-bit PHY address, the 5-bit register address, turnaround 10 and 16 data bits taken from the outgoing data register. Operation bit 0 = 1 selects a read (wire opcode 10), and bit 0 = 0 selects a write (wire opcode 01).
- R4: In extended framing (bit 24 = 1) the start code is 00 and the wire opcode equals the operation field: 00 address, 01 write, 10 read with increment, 11 read. Operations with bit 1 set are reads. Address and write frames carry the outgoing data register.
- R5: With configuration bit 12 set, each frame begins with 32 driven ones. With it clear, no preamble is sent.
- R6: MDC is low for H and then high for H core clocks per bit, where H is configuration bits 7:0 (0 counts as 1). A frame has exactly (preamble + 32) MDC rising edges and lasts (preamble + 32)·2H core clocks from command acceptance to pending clearing. Between frames MDC rests at configuration bit 13.
- R7: In a read, `mdio_oe` is low for the last 18 bits (turnaround and data), and is low whenever no frame runs. Each data bit is sampled in core-clock count min(bits 11:8, 2H−1) of its bit, counted from 0 at the start of the bit. The 16 bits land MSB first in the returned data register, and at frame end valid is set and pending is cleared.
- R8: An accepted read sets returned-data pending and clears its valid. An accepted write or address command does the same on the outgoing data register. At frame end the pending flag clears and the valid flag sets.
- R9: A command written while a frame runs is ignored: the command register and the wire do not change, and each accepted command produces exactly one frame.
- R10: Writing 0 to enable bit 0 aborts any frame, releases MDIO, clears both pending flags and causes commands to be ignored. Writing 1 when disabled forces configuration bit 24 to 0 and keeps the other configuration fields.
- R11: If no device drives MDIO during a read (the line idles high), the returned data is 0xFFFF with valid set.
- R12: The configuration register stores bits 7:0, 11:8, 12, 13, 15, 20:16 and 24, reads back 0 in all other bits, and ignores writes to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 3 | Register index (byte offset / 8) |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data of the selected index |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The block has no build-time parameters, so the bench builds it as-is and instead sweeps the run-time configuration. It covers half periods 0 to 3 (so the zero-clamp is exercised), both framings with all four operation codes each, preamble on and off, both idle levels, and sample points at the rising edge, at the last clock of the bit and beyond the bit. These short periods keep each frame under 400 core clocks, so the full cross of 64 frames is affordable. Every wire bit, MDC edge count and frame duration is checked against values computed from the configuration.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_word,
  input  logic        bus_we,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [5:0] PRE_LEN = 6'd32;
  localparam logic [5:0] FRM_LEN = 6'd32;

  logic [4:0]  c_reg, c_phy;
  logic [1:0]  c_op;
  logic [15:0] wr_data, rd_data, rx;
  logic        wr_val, wr_pend, rd_val, rd_pend;
  logic [7:0]  ck_phase;
  logic [3:0]  ck_samp;
  logic [4:0]  ck_shi;
  logic        ck_pre, ck_idle, ck_smode, ck_c45, en;
  logic        busy, is_rd;
  logic [5:0]  pre_left, bits_left;
  logic [31:0] sh;
  logic [8:0]  cnt;

  wire unused_bits = ^{bus_wdata[63:25], bus_wdata[23:21]};

  wire [8:0]  half    = (ck_phase == 8'd0) ? 9'd1 : {1'b0, ck_phase};
  wire [8:0]  bit_end = {half[7:0], 1'b0} - 9'd1;
  wire [8:0]  samp_at = ({5'd0, ck_samp} > bit_end) ? bit_end : {5'd0, ck_samp};
  wire        in_pre  = pre_left != 6'd0;
  wire        take    = busy && is_rd && !in_pre && bits_left <= 6'd16 && cnt == samp_at;
  wire [15:0] rx_nx   = take ? {rx[14:0], mdio_i} : rx;

  wire        cmd_go  = bus_we && bus_word == 3'd0 && en && !busy;
  wire [1:0]  op_w    = bus_wdata[17:16];
  wire        rd_new  = ck_c45 ? op_w[1] : op_w[0];
  wire [1:0]  wop     = ck_c45 ? op_w : (op_w[0] ? 2'b10 : 2'b01);
  wire [1:0]  st      = ck_c45 ? 2'b00 : 2'b01;
  wire [31:0] frame   = {st, wop, bus_wdata[12:8], bus_wdata[4:0], 2'b10, wr_data};

  assign mdc     = busy ? (cnt >= half) : ck_idle;
  assign mdio_o  = busy ? (in_pre | sh[31]) : 1'b1;
  assign mdio_oe = busy && !(is_rd && !in_pre && bits_left <= 6'd18);

  always_comb begin
    case (bus_word)
      3'd0:    bus_rdata = {46'd0, c_op, 3'd0, c_phy, 3'd0, c_reg};
      3'd1:    bus_rdata = {46'd0, wr_pend, wr_val, wr_data};
      3'd2:    bus_rdata = {46'd0, rd_pend, rd_val, rd_data};
      3'd3:    bus_rdata = {39'd0, ck_c45, 3'd0, ck_shi, ck_smode, 1'b0,
                            ck_idle, ck_pre, ck_samp, ck_phase};
      3'd4:    bus_rdata = {63'd0, en};
      default: bus_rdata = 64'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_op, c_phy, c_reg} <= '0;
      wr_data <= '0; rd_data <= '0; rx <= '0;
      {wr_val, wr_pend, rd_val, rd_pend} <= '0;
      ck_phase <= 8'd5; ck_samp <= 4'd2; ck_pre <= 1'b1; ck_idle <= 1'b0;
      ck_smode <= 1'b0; ck_shi <= '0; ck_c45 <= 1'b0; en <= 1'b1;
      busy <= 1'b0; is_rd <= 1'b0; pre_left <= '0; bits_left <= '0;
      sh <= '0; cnt <= '0;
    end else begin
      if (bus_we) begin
        case (bus_word)
          3'd0: if (cmd_go) {c_op, c_phy, c_reg} <= {op_w, bus_wdata[12:8], bus_wdata[4:0]};
          3'd1: wr_data <= bus_wdata[15:0];
          3'd3: begin
            ck_phase <= bus_wdata[7:0];  ck_samp <= bus_wdata[11:8];
            ck_pre   <= bus_wdata[12];   ck_idle <= bus_wdata[13];
            ck_smode <= bus_wdata[15];   ck_shi  <= bus_wdata[20:16];
            ck_c45   <= bus_wdata[24];
          end
          3'd4: begin
            en <= bus_wdata[0];
            if (bus_wdata[0] && !en) ck_c45 <= 1'b0;
          end
          default: ;
        endcase
      end
      rx <= rx_nx;
      if (!en) begin
        busy <= 1'b0; wr_pend <= 1'b0; rd_pend <= 1'b0;
      end else if (cmd_go) begin
        busy <= 1'b1; is_rd <= rd_new; cnt <= '0; sh <= frame;
        pre_left <= ck_pre ? PRE_LEN : 6'd0;
        bits_left <= FRM_LEN;
        if (rd_new) begin rd_pend <= 1'b1; rd_val <= 1'b0; end
        else begin wr_pend <= 1'b1; wr_val <= 1'b0; end
      end else if (busy) begin
        if (cnt == bit_end) begin
          cnt <= '0;
          if (in_pre) pre_left <= pre_left - 6'd1;
          else begin
            sh <= sh << 1;
            bits_left <= bits_left - 6'd1;
            if (bits_left == 6'd1) begin
              busy <= 1'b0;
              if (is_rd) begin rd_pend <= 1'b0; rd_val <= 1'b1; rd_data <= rx_nx; end
              else begin wr_pend <= 1'b0; wr_val <= 1'b1; end
            end
          end
        end else cnt <= cnt + 9'd1;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        busy,
  input logic        wr_pend,
  input logic        rd_pend,
  input logic        rd_val,
  input logic        mdio_oe,
  input logic        bus_we,
  input logic [2:0]  bus_word,
  input logic [11:0] cmd_w
);
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R7
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wr_pend ^ rd_pend)); // R8
  AST_RD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_val) |-> $fell(rd_pend)); // R7
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_word == 3'd0) |=> $stable(cmd_w)); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !mdio_oe)); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .wr_pend(wr_pend),
  .rd_pend(rd_pend), .rd_val(rd_val), .mdio_oe(mdio_oe), .bus_we(bus_we),
  .bus_word(bus_word), .cmd_w({c_op, c_phy, c_reg})
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_word = '0;
  logic bus_we = 1'b0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  int total = 0, bad = 0;
  int rises = 0, ncap = 0, pre_n = 0;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  logic floatp = 1'b0;

  always #10 clk = ~clk;

  mdio_mgmt_master u0 (.clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    rises = rises + 1;
    if (mdio_oe) begin cap = {cap[62:0], mdio_o}; ncap = ncap + 1; end
  end

  always_comb begin
    int idx;
    idx = rises - 1 - pre_n;
    if (mdio_oe) mdio_i = mdio_o;
    else if (floatp || idx < 16 || idx > 31) mdio_i = 1'b1;
    else mdio_i = resp[31 - idx];
  end

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  task automatic bus_w(input logic [2:0] w, input logic [63:0] d);
    @(negedge clk); bus_word = w; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] w, output logic [63:0] d);
    bus_word = w; #1 d = bus_rdata;
  endtask

  task automatic frame(input bit c45, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd, input bit pre,
                       input int ph, input int sp, input bit idle,
                       input logic [15:0] rsp, input bit flt);
    int h, k, nd;
    bit isrd;
    logic [1:0] wop, stc;
    logic [31:0] fr;
    logic [63:0] full, d, expd;
    logic [2:0] dw;
    h = (ph == 0) ? 1 : ph;
    bus_w(3'd3, 64'(ph) | (64'(sp) << 8) | (64'(pre) << 12) | (64'(idle) << 13) | (64'(c45) << 24));
    bus_w(3'd1, {48'd0, wd});
    resp = rsp; floatp = flt; pre_n = pre ? 32 : 0; rises = 0; ncap = 0; cap = '0;
    isrd = c45 ? op[1] : op[0];
    wop  = c45 ? op : (op[0] ? 2'b10 : 2'b01);
    stc  = c45 ? 2'b00 : 2'b01;
    fr   = {stc, wop, phy, rg, 2'b10, wd};
    full = pre ? {32'hFFFF_FFFF, fr} : {32'd0, fr};
    expd = isrd ? (full >> 18) : full;
    nd   = pre_n + (isrd ? 14 : 32);
    dw   = isrd ? 3'd2 : 3'd1;
    bus_w(3'd0, (64'(op) << 16) | (64'(phy) << 8) | 64'(rg));
    peek(dw, d);
    chk("R8 pending set", {62'd0, d[17:16]}, 64'd2);
    k = 0;
    while (d[17] && k < 5000) begin @(negedge clk); k++; peek(dw, d); end
    chk("R6 frame length", 64'(k), 64'((pre_n + 32) * 2 * h));
    chk("R6 mdc rises", 64'(rises), 64'(pre_n + 32));
    chk("R5 driven bit count", 64'(ncap), 64'(nd));
    if (c45) chk("R4 wire bits", cap, expd);
    else     chk("R3 wire bits", cap, expd);
    if (isrd) chk(flt ? "R11 float read" : "R7 read data", d, {46'd0, 2'b01, flt ? 16'hFFFF : rsp});
    else      chk("R8 write done", d, {46'd0, 2'b01, wd});
    chk("R6 idle level", {63'd0, mdc}, {63'd0, idle});
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int h, sp;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(3'd0, d); chk("R1 cmd", d, 64'd0);
    peek(3'd1, d); chk("R1 wdat", d, 64'd0);
    peek(3'd2, d); chk("R1 rdat", d, 64'd0);
    peek(3'd3, d); chk("R1 clkcfg", d, 64'h1205);
    peek(3'd4, d); chk("R1 enable", d, 64'd1);
    chk("R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);
    // R12 config fields
    bus_w(3'd3, 64'h0000_0000_011F_A53C);
    peek(3'd3, d); chk("R12 clk fields", d, 64'h011F_A53C);
    bus_w(3'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(3'd3, d); chk("R12 clk mask", d, 64'h011F_BFFF);
    // sweep R3 R4 R5 R6 R7 R8 R11
    for (int c = 0; c < 2; c++)
      for (int op = 0; op < 4; op++)
        for (int ph = 0; ph < 4; ph++)
          for (int pre = 0; pre < 2; pre++) begin
            h = (ph == 0) ? 1 : ph;
            case ((op + ph + pre) % 3)
              0: sp = h;
              1: sp = 2 * h - 1;
              default: sp = 15;
            endcase
            frame(c[0], op[1:0], 5'(op * 7 + ph + 3), 5'(ph * 9 + pre + op),
                  16'(16'hA5C3 ^ (op * 4099 + ph * 257 + c * 31 + pre)),
                  pre[0], ph, sp, op[0] ^ ph[0],
                  16'(16'h6E19 ^ (ph * 1031 + op * 77 + c * 5)),
                  (c == 1 && op == 3 && ph == 2));
          end
    frame(1'b0, 2'b01, 5'd1, 5'd2, 16'h0, 1'b0, 2, 3, 1'b0, 16'h1234, 1'b1); // R11
    // R2 and R9: command readback and ignored command
    bus_w(3'd3, 64'h0000_0101);
    rises = 0;
    bus_w(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(3'd0, d); chk("R2 cmd fields", d, 64'h3_1F1F);
    bus_w(3'd0, 64'h0000_0000_0001_0203);
    peek(3'd0, d); chk("R9 cmd ignored", d, 64'h3_1F1F);
    repeat (200) @(negedge clk);
    chk("R9 one frame", 64'(rises), 64'd32);
    // R10 abort and re-enable
    bus_w(3'd3, 64'h0100_1003);
    rises = 0;
    bus_w(3'd0, 64'h0000_0000_0000_0105);
    repeat (40) @(negedge clk);
    bus_w(3'd4, 64'd0);
    @(negedge clk);
    peek(3'd1, d); chk("R10 pending cleared", {63'd0, d[17]}, 64'd0);
    chk("R10 released", {63'd0, mdio_oe}, 64'd0);
    rises = 0;
    bus_w(3'd0, 64'h0000_0000_0002_0000);
    repeat (50) @(negedge clk);
    chk("R10 no frame when off", 64'(rises), 64'd0);
    peek(3'd0, d); chk("R10 cmd ignored when off", d, 64'h0105);
    bus_w(3'd4, 64'd1);
    peek(3'd3, d); chk("R10 mode reset", d, 64'h0000_1003);
    frame(1'b0, 2'b00, 5'd9, 5'd17, 16'hBEEF, 1'b1, 1, 1, 1'b1, 16'h0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule